// File: doc/BRIEF.md
# Dual-View Integer Register File

This block is a 64-entry by 64-bit integer register file. Software can reach it in two ways. The full view addresses every entry at 64 bits. The narrow view reaches only the lowest 16 entries and treats each one as a 32-bit register. The highest entry is wired to zero: reads of it return zero, and writes to it are dropped.

In the narrow view, a write takes the 32-bit value and sign-extends it to 64 bits before storing it. A narrow read returns the low 32 bits of the entry and clears the upper half. So a narrow write followed by a full read shows the sign extension, but a narrow read never does.

The block has two read ports and one write port. Each port has its own view select, so each access picks its view independently. Reads are combinational from the stored state. The single write takes effect on the rising clock edge. There is no write-through: a read in the same cycle as a write to the same entry returns the old value.

Top module: `dual_view_regfile`

## Requirements
- R1: While reset is asserted and after it is released, every entry reads as zero through the full view (view select 0).
- R2: A full-view write (view select 0) to entry i, where i is not the last entry, stores all 64 bits. A full-view read of entry i in a later cycle returns that value.
- R3: A full-view read of entry 63 always returns zero.
- R4: A full-view write to entry 63 changes no entry. Entry 63 still reads zero, and all other entries keep their contents.
- R5: A narrow-view read (view select 1) of index i returns bits 31:0 of entry i in bits 31:0 of the output, with bits 63:32 equal to zero.
- R6: A narrow-view write of value v to index i stores v[31:0] in bits 31:0 of entry i and copies v[31] into every bit of 63:32.
- R7: In the narrow view, index bits 5:4 are ignored on reads and on writes. Only bits 3:0 select the entry.
- R8: With the write enable low, no entry changes at the clock edge.
- R9: A read of an entry in the same cycle as a write to it returns the value from before the write.
- R10: The two read ports are independent. Each port returns its own entry in its own view in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the write takes effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears every entry |
| wr_en | input | 1 | Write enable |
| wr_view | input | 1 | Write view: 0 selects the full view, 1 the narrow view |
| wr_idx | input | 6 | Write index |
| wr_data | input | 64 | Write data; the narrow view uses bits 31:0 |
| rd0_view | input | 1 | Read port 0 view select |
| rd0_idx | input | 6 | Read port 0 index |
| rd0_data | output | 64 | Read port 0 data |
| rd1_view | input | 1 | Read port 1 view select |
| rd1_idx | input | 6 | Read port 1 index |
| rd1_data | output | 64 | Read port 1 data |

## Verification
The bound checker watches both read ports on every cycle. It checks that:
- entry 63 reads zero in the full view;
- a narrow read always returns a zero upper half;
- a full-view write is visible one cycle later;
- a narrow write shows up sign-extended;
- the read data holds steady when nothing is written and the read inputs do not change.

Some behaviours need a history that only the bench's scenarios can show:
- the drop of a write to entry 63 while the other entries are left untouched;
- the ignored narrow index bits;
- the old value returned during a same-cycle write;
- the full clear at reset.

The bench checks these against its own model of the register file.

// File: rtl/dvrf_pkg.sv
package dvrf_pkg;
   typedef enum logic {
      VIEW_FULL   = 1'b0,
      VIEW_NARROW = 1'b1
   } view_e;
endpackage

// File: rtl/dvrf_wr_fmt.sv
module dvrf_wr_fmt #(
   parameter int DATA_W      = 64,
   parameter int NUM_REGS    = 64,
   parameter int NARROW_W    = 32,
   parameter int NARROW_REGS = 16,
   localparam int IDX_W      = $clog2(NUM_REGS),
   localparam int NIDX_W     = $clog2(NARROW_REGS)
) (
   input  logic              en_i,
   input  logic              view_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              we_o,
   output logic [IDX_W-1:0]  waddr_o,
   output logic [DATA_W-1:0] wdata_o
);
   localparam int EXT_W = DATA_W - NARROW_W;

   logic [NARROW_W-1:0] narrow_val;
   assign narrow_val = data_i[NARROW_W-1:0];

   always_comb begin
      we_o = en_i;
      if (view_i == dvrf_pkg::VIEW_NARROW) begin
         waddr_o = IDX_W'(idx_i[NIDX_W-1:0]);
         wdata_o = {{EXT_W{narrow_val[NARROW_W-1]}}, narrow_val};
      end else begin
         waddr_o = idx_i;
         wdata_o = data_i;
      end
   end
endmodule

// File: rtl/dvrf_store.sv
module dvrf_store #(
   parameter int DATA_W     = 64,
   parameter int NUM_REGS   = 64,
   parameter bit ZERO_LAST  = 1'b1,
   localparam int IDX_W     = $clog2(NUM_REGS)
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we_i,
   input  logic [IDX_W-1:0]                 waddr_i,
   input  logic [DATA_W-1:0]                wdata_i,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
   for (genvar e = 0; e < NUM_REGS; e++) begin : g_entry
      if (ZERO_LAST && (e == NUM_REGS - 1)) begin : g_hard_zero
         assign regs_o[e] = '0;
      end else begin : g_flop
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (we_i && (waddr_i == IDX_W'(e))) begin
               q <= wdata_i;
            end
         end
         assign regs_o[e] = q;
      end
   end
endmodule

// File: rtl/dvrf_rd_fmt.sv
module dvrf_rd_fmt #(
   parameter int DATA_W      = 64,
   parameter int NUM_REGS    = 64,
   parameter int NARROW_W    = 32,
   parameter int NARROW_REGS = 16,
   localparam int IDX_W      = $clog2(NUM_REGS),
   localparam int NIDX_W     = $clog2(NARROW_REGS)
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0] regs_i,
   input  logic                            view_i,
   input  logic [IDX_W-1:0]                idx_i,
   output logic [DATA_W-1:0]               data_o
);
   logic [DATA_W-1:0] narrow_entry;
   assign narrow_entry = regs_i[idx_i[NIDX_W-1:0]];

   always_comb begin
      if (view_i == dvrf_pkg::VIEW_NARROW) begin
         data_o = '0;
         data_o[NARROW_W-1:0] = narrow_entry[NARROW_W-1:0];
      end else begin
         data_o = regs_i[idx_i];
      end
   end
endmodule

// File: rtl/dual_view_regfile.sv
module dual_view_regfile #(
   parameter int DATA_W      = 64,
   parameter int NUM_REGS    = 64,
   parameter int NARROW_W    = 32,
   parameter int NARROW_REGS = 16,
   parameter bit ZERO_LAST   = 1'b1,
   localparam int IDX_W      = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_view,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd0_view,
   input  logic [IDX_W-1:0]  rd0_idx,
   output logic [DATA_W-1:0] rd0_data,
   input  logic              rd1_view,
   input  logic [IDX_W-1:0]  rd1_idx,
   output logic [DATA_W-1:0] rd1_data
);
   localparam int NUM_RD = 2;

   if (NARROW_REGS > NUM_REGS) begin : g_bad_depth
      $error("narrow view deeper than register file");
   end
   if (NARROW_W > DATA_W) begin : g_bad_width
      $error("narrow view wider than register file");
   end
   if ((2 ** IDX_W) != NUM_REGS) begin : g_bad_pow2
      $error("register count must be a power of two");
   end

   logic                             we;
   logic [IDX_W-1:0]                 waddr;
   logic [DATA_W-1:0]                wdata;
   logic [NUM_REGS-1:0][DATA_W-1:0]  regs;

   logic [NUM_RD-1:0]                rd_view;
   logic [NUM_RD-1:0][IDX_W-1:0]     rd_idx;
   logic [NUM_RD-1:0][DATA_W-1:0]    rd_data;

   assign rd_view  = {rd1_view, rd0_view};
   assign rd_idx   = {rd1_idx, rd0_idx};
   assign rd0_data = rd_data[0];
   assign rd1_data = rd_data[1];

   dvrf_wr_fmt #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
      .NARROW_W(NARROW_W), .NARROW_REGS(NARROW_REGS)
   ) wr_fmt_i (
      .en_i(wr_en), .view_i(wr_view), .idx_i(wr_idx), .data_i(wr_data),
      .we_o(we), .waddr_o(waddr), .wdata_o(wdata)
   );

   dvrf_store #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .ZERO_LAST(ZERO_LAST)
   ) store_i (
      .clk(clk), .rst_n(rst_n), .we_i(we), .waddr_i(waddr),
      .wdata_i(wdata), .regs_o(regs)
   );

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      dvrf_rd_fmt #(
         .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
         .NARROW_W(NARROW_W), .NARROW_REGS(NARROW_REGS)
      ) rd_fmt_i (
         .regs_i(regs), .view_i(rd_view[p]), .idx_i(rd_idx[p]),
         .data_o(rd_data[p])
      );
   end
endmodule

// File: rtl/dvrf_checker.sv
module dvrf_checker #(
   parameter int DATA_W      = 64,
   parameter int NUM_REGS    = 64,
   parameter int NARROW_W    = 32,
   parameter int NARROW_REGS = 16,
   localparam int IDX_W      = $clog2(NUM_REGS),
   localparam int NIDX_W     = $clog2(NARROW_REGS),
   localparam int EXT_W      = DATA_W - NARROW_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_view,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd0_view,
   input logic [IDX_W-1:0]  rd0_idx,
   input logic [DATA_W-1:0] rd0_data,
   input logic              rd1_view,
   input logic [IDX_W-1:0]  rd1_idx,
   input logic [DATA_W-1:0] rd1_data
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

   AST_ZERO_REG_P0: assert property (@(posedge clk) disable iff (!rst_n)
      (rd0_view == 1'b0 && rd0_idx == LAST) |-> rd0_data == '0); // R3
   AST_ZERO_REG_P1: assert property (@(posedge clk) disable iff (!rst_n)
      (rd1_view == 1'b0 && rd1_idx == LAST) |-> rd1_data == '0); // R3
   AST_NARROW_UPPER_P0: assert property (@(posedge clk) disable iff (!rst_n)
      rd0_view |-> rd0_data[DATA_W-1:NARROW_W] == '0); // R5
   AST_NARROW_UPPER_P1: assert property (@(posedge clk) disable iff (!rst_n)
      rd1_view |-> rd1_data[DATA_W-1:NARROW_W] == '0); // R5
   AST_FULL_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en) && !$past(wr_view) && $past(wr_idx) != LAST
       && !rd0_view && rd0_idx == $past(wr_idx))
      |-> rd0_data == $past(wr_data)); // R2
   AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en) && $past(wr_view) && !rd0_view
       && rd0_idx == IDX_W'($past(wr_idx[NIDX_W-1:0])))
      |-> rd0_data == {{EXT_W{$past(wr_data[NARROW_W-1])}},
                       $past(wr_data[NARROW_W-1:0])}); // R6
   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(wr_en) && $stable(rd0_view) && $stable(rd0_idx))
      |-> $stable(rd0_data)); // R8
endmodule

bind dual_view_regfile dvrf_checker #(
   .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
   .NARROW_W(NARROW_W), .NARROW_REGS(NARROW_REGS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_view(wr_view),
   .wr_idx(wr_idx), .wr_data(wr_data),
   .rd0_view(rd0_view), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
   .rd1_view(rd1_view), .rd1_idx(rd1_idx), .rd1_data(rd1_data)
);

// File: tb/dual_view_regfile_tb_top.sv
module dual_view_regfile_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_view = 1'b0;
   logic [5:0]  wr_idx = '0;
   logic [63:0] wr_data = '0;
   logic        rd0_view = 1'b0;
   logic [5:0]  rd0_idx = '0;
   logic [63:0] rd0_data;
   logic        rd1_view = 1'b0;
   logic [5:0]  rd1_idx = '0;
   logic [63:0] rd1_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [63:0] model [64];

   always #10ns clk = ~clk;

   dual_view_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_view(wr_view),
      .wr_idx(wr_idx), .wr_data(wr_data),
      .rd0_view(rd0_view), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
      .rd1_view(rd1_view), .rd1_idx(rd1_idx), .rd1_data(rd1_data)
   );

   function automatic logic [63:0] exp_rd(input logic v, input logic [5:0] i);
      if (v) return {32'h0, model[i[3:0]][31:0]};
      if (i == 6'd63) return 64'h0;
      return model[i];
   endfunction

   function automatic void model_wr(input logic en, input logic v,
                                    input logic [5:0] i, input logic [63:0] d);
      if (!en) return;
      if (v) model[i[3:0]] = {{32{d[31]}}, d[31:0]};
      else if (i != 6'd63) model[i] = d;
   endfunction

   function automatic string auto_tag(input logic v, input logic [5:0] i);
      if (v) return "R5";
      if (i == 6'd63) return "R3";
      return "R2";
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step(input logic en, input logic wv, input logic [5:0] wi,
                       input logic [63:0] wd, input logic r0v, input logic [5:0] r0i,
                       input logic r1v, input logic [5:0] r1i, input string tag);
      @(negedge clk);
      wr_en = en; wr_view = wv; wr_idx = wi; wr_data = wd;
      rd0_view = r0v; rd0_idx = r0i; rd1_view = r1v; rd1_idx = r1i;
      #1ns;
      chk(tag == "" ? auto_tag(r0v, r0i) : tag, rd0_data, exp_rd(r0v, r0i));
      chk(tag == "" ? auto_tag(r1v, r1i) : tag, rd1_data, exp_rd(r1v, r1i));
      @(posedge clk);
      model_wr(en, wv, wi, wd);
   endtask

   initial begin
      repeat (1500000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1234_5678));
      for (int k = 0; k < 64; k++) model[k] = '0;
      repeat (3) @(negedge clk);
      #1ns;
      chk("R1", rd0_data, 64'h0);
      rst_n = 1'b1;
      // R1: every entry zero after reset
      for (int k = 0; k < 32; k++)
         step(1'b0, 1'b0, 6'd0, 64'h0, 1'b0, 6'(k), 1'b0, 6'(k + 32), "R1");
      // R2 full write then read
      step(1'b1, 1'b0, 6'd10, 64'hDEAD_BEEF_0123_4567, 1'b0, 6'd0, 1'b0, 6'd0, "");
      step(1'b0, 1'b0, 6'd0, 64'h0, 1'b0, 6'd10, 1'b0, 6'd10, "R2");
      // R4 write to entry 63 dropped; neighbour kept
      step(1'b1, 1'b0, 6'd62, 64'h1111_2222_3333_4444, 1'b0, 6'd0, 1'b0, 6'd0, "");
      step(1'b1, 1'b0, 6'd63, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 6'd63, 1'b0, 6'd62, "R4");
      step(1'b0, 1'b0, 6'd0, 64'h0, 1'b0, 6'd63, 1'b0, 6'd62, "R4");
      // R6 sign extension, negative and positive
      step(1'b1, 1'b1, 6'd5, 64'hAAAA_AAAA_8000_0001, 1'b0, 6'd0, 1'b0, 6'd0, "");
      step(1'b0, 1'b0, 6'd0, 64'h0, 1'b0, 6'd5, 1'b1, 6'd5, "R6");
      chk("R6", rd0_data, 64'hFFFF_FFFF_8000_0001);
      step(1'b1, 1'b1, 6'd6, 64'hFFFF_FFFF_7FFF_FFFE, 1'b0, 6'd0, 1'b0, 6'd0, "");
      step(1'b0, 1'b0, 6'd0, 64'h0, 1'b0, 6'd6, 1'b0, 6'd6, "R6");
      chk("R6", rd0_data, 64'h0000_0000_7FFF_FFFE);
      // R5 narrow read of full-width entry
      step(1'b0, 1'b0, 6'd0, 64'h0, 1'b1, 6'd10, 1'b0, 6'd10, "R5");
      chk("R5", rd0_data, 64'h0000_0000_0123_4567);
      // R7 upper narrow index bits ignored
      step(1'b1, 1'b1, 6'h37, 64'h0000_0000_CAFE_F00D, 1'b1, 6'h25, 1'b0, 6'd7, "R7");
      step(1'b0, 1'b0, 6'd0, 64'h0, 1'b1, 6'h17, 1'b0, 6'd7, "R7");
      chk("R7", rd1_data, 64'hFFFF_FFFF_CAFE_F00D);
      step(1'b0, 1'b0, 6'd0, 64'h0, 1'b0, 6'h37, 1'b0, 6'h27, "R7");
      // R8 write enable low
      step(1'b0, 1'b0, 6'd10, 64'h5555_5555_5555_5555, 1'b0, 6'd0, 1'b0, 6'd0, "");
      step(1'b0, 1'b0, 6'd0, 64'h0, 1'b0, 6'd10, 1'b1, 6'd10, "R8");
      chk("R8", rd0_data, 64'hDEAD_BEEF_0123_4567);
      // R9 same-cycle read returns old value
      step(1'b1, 1'b0, 6'd10, 64'h9999_8888_7777_6666, 1'b0, 6'd10, 1'b1, 6'd10, "R9");
      chk("R9", rd0_data, 64'hDEAD_BEEF_0123_4567);
      // R10 ports independent, mixed views
      step(1'b0, 1'b0, 6'd0, 64'h0, 1'b1, 6'd5, 1'b0, 6'd10, "R10");
      chk("R10", rd1_data, 64'h9999_8888_7777_6666);
      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [63:0] d;
         d = {$urandom, $urandom};
         step(1'($urandom), 1'($urandom), 6'($urandom), d,
              1'($urandom), 6'($urandom), 1'($urandom), 6'($urandom), "");
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule